// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, frame by frame, whether the frame is kept. It watches the byte stream as it arrives, collects the first six bytes (the destination address), and checks them against its configuration. That configuration has three parts: a set of exact-match address slots, a 64-bin multicast hash table, and three mode bits. The mode bits select accept-everything, hash lookup for multicast, and rejection of broadcast.

Software or a neighbouring block programs the filter through a single-cycle write port. Each exact-match slot takes two writes. A slot is switched off by the write of its lower four bytes and switched back on by the write of its upper two bytes, so a slot caught halfway through an update never matches. Slot 0 is meant for the station's own unicast address, and the other slots suit multicast groups. One decision pulse comes out per frame, one clock after the sixth address byte.

Top module: `rx_da_filter`

## Requirements
- R1: After reset all slots are inactive, all mode bits and hash bits are zero, and `dec_vld` is low. A unicast frame is then rejected and a broadcast frame is accepted.
- R2: `dec_vld` is high for exactly one cycle, the cycle after the sixth address byte is sampled. Bytes that arrive before any `rx_sof`, and bytes after the sixth, produce no decision.
- R3: Byte 0 is the first byte received. Slot k's low word is written at address 8+2k and carries bytes 3..0, with byte 0 in bits 7:0. Its high word is written at 9+2k and carries byte 5 in bits 15:8 and byte 4 in bits 7:0. A frame whose address equals an active slot is accepted, and an address that differs in any byte is not matched.
- R4: Writing a slot's low word deactivates that slot. Writing its high word reactivates it.
- R5: The hash index is 6 bits wide. Address bit 8*o+b (octet o, bit b) is XORed into index bit (8*o+b) mod 6.
- R6: The hash table is written as a low word at address 2 (bins 0–31) and a high word at address 3 (bins 32–63). A frame is multicast when bit 0 of byte 0 is 1. A multicast frame is accepted by the hash only when control bit 1 (hash enable) is set and its bin is set. A unicast frame is never accepted by the hash.
- R7: With all 64 hash bits set and hash enable on, every multicast frame is accepted.
- R8: Control bit 0 (copy-all), written at address 0, makes every frame accepted whatever its address.
- R9: The all-ones address is broadcast and is judged before any slot or hash lookup. It is accepted unless control bit 2 (broadcast disable) is set. Copy-all still accepts it.
- R10: An `rx_sof` in the middle of an address discards the partial address and starts a new one, so only the new frame gets a decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_vld) |
| rx_vld | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Accept (1) or reject (0), meaningful while dec_vld is high |

## Verification
The assertions assume that configuration writes do not change the mode bits between the sampling of the sixth byte and the decision edge. They also assume that a new frame takes at least six bytes, which is why two decision strobes are never adjacent. The stimulus keeps to this by issuing every write between frames, never while an address is in flight. Every frame is a full six-byte address driven one byte per cycle, apart from the deliberately cut-short frame used for the restart case.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int DA_BITS    = 48;
    localparam int DA_BYTES   = DA_BITS / 8;
    localparam int HASH_BITS  = 6;
    localparam int HASH_BINS  = 1 << HASH_BITS;
    localparam int REG_CTRL   = 0;
    localparam int REG_HLO    = 2;
    localparam int REG_HHI    = 3;
    localparam int REG_SLOT0  = 8;

    typedef logic [DA_BITS-1:0] mac_addr_t;

    typedef struct packed {
        logic bcast_dis;
        logic hash_en;
        logic copy_all;
    } rx_ctl_t;

    typedef struct packed {
        logic      active;
        mac_addr_t addr;
    } xm_slot_t;

    // Fold the address onto HASH_BITS bits: bit j lands on j mod HASH_BITS.
    function automatic logic [HASH_BITS-1:0] da_hash(input mac_addr_t a);
        logic [HASH_BITS-1:0] h;
        h = '0;
        for (int j = 0; j < DA_BITS; j++) h[j % HASH_BITS] ^= a[j];
        return h;
    endfunction

    function automatic logic is_bcast(input mac_addr_t a);
        return &a;
    endfunction

    function automatic logic is_mcast(input mac_addr_t a);
        return a[0];
    endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int N_SLOT = 8,
    parameter int CFG_AW = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [CFG_AW-1:0]     addr,
    input  logic [31:0]           wdata,
    output rx_ctl_t               ctl,
    output logic [HASH_BINS-1:0]  hash_tbl,
    output xm_slot_t              slots [N_SLOT]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            hash_tbl <= '0;
        end else if (we) begin
            if (addr == CFG_AW'(REG_CTRL)) ctl <= rx_ctl_t'(wdata[2:0]);
            if (addr == CFG_AW'(REG_HLO))  hash_tbl[31:0]  <= wdata;
            if (addr == CFG_AW'(REG_HHI))  hash_tbl[63:32] <= wdata;
        end
    end

    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
        localparam int LO_A = REG_SLOT0 + 2 * k;
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[k] <= '0;
            end else if (we && addr == CFG_AW'(LO_A)) begin
                slots[k].addr[31:0] <= wdata;
                slots[k].active     <= 1'b0;
            end else if (we && addr == CFG_AW'(LO_A + 1)) begin
                slots[k].addr[47:32] <= wdata[15:0];
                slots[k].active      <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxf_da_capture.sv
module rxf_da_capture
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sof,
    input  logic      bvld,
    input  logic [7:0] bdata,
    output logic      da_last,
    output mac_addr_t da_next
);
    localparam int CW = $clog2(DA_BYTES + 1);

    logic [CW-1:0]          cnt;
    logic [DA_BITS-9:0]     da_q;
    logic                   take;
    logic [CW-1:0]          idx;

    assign idx     = sof ? '0 : cnt;
    assign take    = bvld && (sof || (cnt != '0 && cnt < CW'(DA_BYTES)));
    assign da_last = take && (idx == CW'(DA_BYTES - 1));
    assign da_next = {bdata, da_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            da_q <= '0;
        end else if (take) begin
            cnt <= idx + CW'(1);
            if (sof) begin
                da_q <= {{(DA_BITS-16){1'b0}}, bdata};
            end else begin
                for (int b = 1; b < DA_BYTES - 1; b++)
                    if (idx == CW'(b)) da_q[b*8 +: 8] <= bdata;
            end
        end
    end
endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
#(
    parameter int N_SLOT = 8
) (
    input  rx_ctl_t              ctl,
    input  logic [HASH_BINS-1:0] hash_tbl,
    input  xm_slot_t             slots [N_SLOT],
    input  mac_addr_t            da,
    output logic                 any_hit,
    output logic                 accept
);
    logic [N_SLOT-1:0] hit;

    for (genvar k = 0; k < N_SLOT; k++) begin : g_cmp
        assign hit[k] = slots[k].active && (slots[k].addr == da);
    end

    assign any_hit = |hit;

    always_comb begin
        if (ctl.copy_all)
            accept = 1'b1;
        else if (is_bcast(da))
            accept = !ctl.bcast_dis;
        else if (any_hit)
            accept = 1'b1;
        else
            accept = is_mcast(da) && ctl.hash_en && hash_tbl[da_hash(da)];
    end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import rxf_pkg::*;
#(
    parameter int N_SLOT = 8,
    parameter int CFG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              rx_sof,
    input  logic              rx_vld,
    input  logic [7:0]        rx_byte,
    output logic              dec_vld,
    output logic              dec_accept
);
    rx_ctl_t              ctl;
    logic [HASH_BINS-1:0] hash_tbl;
    xm_slot_t             slots [N_SLOT];
    logic                 da_last;
    mac_addr_t            da_next;
    logic                 any_hit;
    logic                 accept;

    rxf_cfg_regs #(.N_SLOT(N_SLOT), .CFG_AW(CFG_AW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctl(ctl), .hash_tbl(hash_tbl), .slots(slots)
    );

    rxf_da_capture u_cap (
        .clk(clk), .rst(rst), .sof(rx_sof), .bvld(rx_vld), .bdata(rx_byte),
        .da_last(da_last), .da_next(da_next)
    );

    rxf_match #(.N_SLOT(N_SLOT)) u_match (
        .ctl(ctl), .hash_tbl(hash_tbl), .slots(slots), .da(da_next),
        .any_hit(any_hit), .accept(accept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld    <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_vld    <= da_last;
            dec_accept <= da_last && accept;
        end
    end

    // R2
    dec_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        da_last |=> dec_vld);
    // R2
    dec_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dec_vld |=> !dec_vld);
    // R8
    copy_all_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (da_last && ctl.copy_all) |=> dec_accept);
    // R9
    bcast_block_chk: assert property (@(posedge clk) disable iff (rst)
        (da_last && !ctl.copy_all && ctl.bcast_dis && is_bcast(da_next)) |=> !dec_accept);
    // R6
    hash_off_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (da_last && !ctl.copy_all && !ctl.hash_en && !any_hit && !is_bcast(da_next))
        |=> !dec_accept);
endmodule

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;
    localparam int CLK_NS = 10;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic rx_sof = 1'b0, rx_vld = 1'b0;
    logic [7:0] rx_byte = '0;
    logic dec_vld, dec_accept;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    rx_da_filter #(.N_SLOT(8), .CFG_AW(AW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_sof(rx_sof), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .dec_vld(dec_vld), .dec_accept(dec_accept)
    );

    task automatic chk(input logic act, input logic exp, input string rq);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", rq, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        int i = 0;
        for (int o = 0; o < 6; o++)
            for (int b = 0; b < 8; b++) begin
                h[i] = h[i] ^ a[o*8 + b];
                i = (i == 5) ? 0 : i + 1;
            end
        return h;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic s);
        @(negedge clk);
        rx_vld = 1'b1; rx_byte = b; rx_sof = s;
    endtask

    task automatic idle;
        @(negedge clk);
        rx_vld = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic frame(input logic [47:0] a, input logic exp, input string rq);
        for (int i = 0; i < 6; i++) push(a[i*8 +: 8], i == 0);
        idle();
        chk(dec_vld, 1'b1, {rq, " strobe"});
        chk(dec_accept, exp, rq);
        idle();
    endtask

    function automatic logic [47:0] slot_addr(input int k);
        return {8'(8'hF0 - k), 8'h44, 8'(k * 17), 8'h9C, 8'(8'h20 + k), 8'(k << 2)};
    endfunction

    task automatic set_hash(input logic [63:0] t);
        wr(2, t[31:0]);
        wr(3, t[63:32]);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dec_vld, 1'b0, "R1 reset strobe low");

        // R2: bytes without a start-of-frame give no decision
        for (int i = 0; i < 6; i++) begin
            push(8'h11 * i, 1'b0);
            chk(dec_vld, 1'b0, "R2 no sof");
        end
        idle(); chk(dec_vld, 1'b0, "R2 no sof end");
        idle();

        // R1: defaults
        frame(slot_addr(0), 1'b0, "R1 unicast rejected");
        frame('1, 1'b1, "R1 broadcast accepted");

        // R3: each slot matches its own address, near misses do not
        for (int k = 0; k < 8; k++) begin
            a = slot_addr(k);
            wr(8 + 2*k, a[31:0]);
            wr(9 + 2*k, {16'h0, a[47:32]});
        end
        for (int k = 0; k < 8; k++) begin
            a = slot_addr(k);
            frame(a, 1'b1, "R3 slot match");
            frame(a ^ 48'h0100_0000_0000, 1'b0, "R3 byte5 miss");
            frame(a ^ 48'h0000_0000_0080, 1'b0, "R3 byte0 miss");
        end

        // R4: low write disables, high write enables
        for (int k = 0; k < 8; k++) begin
            a = slot_addr(k);
            wr(8 + 2*k, a[31:0]);
            frame(a, 1'b0, "R4 low write disables");
            if (k < 7) frame(slot_addr(k + 1), 1'b1, "R4 other slot unaffected");
            wr(9 + 2*k, {16'h0, a[47:32]});
            frame(a, 1'b1, "R4 high write enables");
        end

        // R3: a multicast address in slot 7, hash off
        a = 48'h0A0B_0C0D_0E01;
        wr(22, a[31:0]); wr(23, {16'h0, a[47:32]});
        frame(a, 1'b1, "R3 multicast slot");

        // R5/R6: sweep bins with hash enabled
        wr(0, 32'h2);
        for (int j = 0; j < 64; j++) begin
            a = {8'(j*5 + 1), 8'(j ^ 8'h3C), 8'(j*3), 8'hA5, 8'(j), 8'((j << 1) | 1)};
            h = ref_hash(a);
            set_hash(64'h1 << h);
            frame(a, 1'b1, "R5 own bin set");
            set_hash(~(64'h1 << h));
            frame(a, 1'b0, "R5 own bin clear");
        end

        // R6: hash disabled, and unicast never via hash
        a = 48'h1234_5678_9A01;
        set_hash(64'h1 << ref_hash(a));
        wr(0, 32'h0);
        frame(a, 1'b0, "R6 hash disabled");
        wr(0, 32'h2);
        frame(a, 1'b1, "R6 hash enabled");
        set_hash('1);
        frame(48'h1234_5678_9A02, 1'b0, "R6 unicast not hashed");

        // R7: all bins set
        for (int j = 0; j < 6; j++)
            frame({8'(j * 37), 8'h5A, 8'(j), 8'hC3, 8'(j * 9), 8'((j << 3) | 1)},
                  1'b1, "R7 all multicast");

        // R9: broadcast disable overrides hash, copy-all overrides that
        wr(0, 32'h6);
        frame('1, 1'b0, "R9 broadcast blocked");
        frame(slot_addr(2), 1'b1, "R9 slot still matches");
        wr(0, 32'h7);
        frame('1, 1'b1, "R9 copy-all over block");

        // R8: copy-all with nothing else
        wr(0, 32'h1);
        set_hash('0);
        frame(48'h7777_6666_5500, 1'b1, "R8 copy-all unicast");
        frame(48'h0102_0304_0507, 1'b1, "R8 copy-all multicast");
        wr(0, 32'h0);
        frame(48'h7777_6666_5500, 1'b0, "R8 copy-all off");

        // R2: bytes after the sixth are ignored
        for (int i = 0; i < 6; i++) push(slot_addr(1) >> (i*8), i == 0);
        for (int i = 0; i < 4; i++) begin
            push(8'hEE, 1'b0);
            if (i == 0) begin
                chk(dec_vld, 1'b1, "R2 strobe timing");
                chk(dec_accept, 1'b1, "R2 decision");
            end else chk(dec_vld, 1'b0, "R2 trailing bytes");
        end
        idle(); chk(dec_vld, 1'b0, "R2 trailing end");
        idle();

        // R10: restart mid-address
        a = slot_addr(5);
        for (int i = 0; i < 3; i++) begin
            push(8'hFF, i == 0);
            chk(dec_vld, 1'b0, "R10 partial");
        end
        for (int i = 0; i < 6; i++) begin
            push(a[i*8 +: 8], i == 0);
            chk(dec_vld, 1'b0, "R10 no early strobe");
        end
        idle();
        chk(dec_vld, 1'b1, "R10 restart strobe");
        chk(dec_accept, 1'b1, "R10 restart decision");
        idle();
        chk(dec_vld, 1'b0, "R10 single strobe");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule